// File: doc/BRIEF.md
# Packet Header Protocol Interpreter

This block is the protocol controller for one receive channel of a serial link. It watches the channel's received token stream. Every end-of-packet marker is followed by a four-byte header, and the block collects that header. From the header's destination and command bytes it chooses one of four outcomes for the packet:
- forward the rest of the packet to the receive buffer,
- carry out a simple control command,
- pass the header on to the acknowledge path,
- reject the packet with an error code.

It holds the one-shot arming register for safety-critical commands. It drives the CPU reset output and a set of external signal lines, and it keeps the latest transaction-ID byte and control byte for reading. In transparent and routing modes the block is bypassed and reacts to nothing.

Header byte order on the wire:
- byte 0: destination address
- byte 1: command code
- byte 2: transaction ID
- byte 3: control byte

Token results are registered. A token sampled on one clock edge shows its effect on the outputs directly after that edge. Pulse outputs last one cycle.

Top module: `pkt_hdr_interp`

## Requirements
- R1: After synchronous reset, all of the following are 0: every output pulse, the CPU reset, the external signals, the arming flag, and the captured transaction-ID and control bytes.
- R2: In protocol mode, the first four data tokens after reset, after an end-of-packet token, or after re-entering protocol mode form the header (destination, command, transaction ID, control). On the edge that takes the fourth byte, `hdr_tid_o` and `hdr_ctrl_o` take bytes 2 and 3.
- R3: A header whose destination equals `chan_addr_i` and whose command is 0x01 (data write) enables forwarding. Each later payload byte appears on `fwd_data_o` with `fwd_valid_o` on the edge that samples it. The closing end-of-packet token produces `fwd_valid_o` with `fwd_eop_o` = 1.
- R4: A destination that does not match raises `err_valid_o` with code 1 and drops the payload. Checks run in this priority: address mismatch (1), then invalid command (2), then locked safety command (3). A rejected header changes no command output.
- R5: Command codes 0x00 and 0x0F..0xFF are invalid. They give error code 2 and the payload is dropped.
- R6: Command 0x02 sets the arming flag. Running any safety-critical command clears it. The safety-critical commands are 0x03, 0x04, 0x0D and 0x0E.
- R7: A safety-critical command that arrives while the block is not armed gives error code 3. The CPU reset and the reset pulses are left unchanged.
- R8: Command 0x03 sets `cpu_rst_o` to 1 and command 0x04 sets it to 0.
- R9: Command 0x05+i sets `ext_sig_o[i]` and command 0x09+i clears it, for i = 0..3. These commands do not need arming and do not clear it.
- R10: Command 0x0D gives a one-cycle `link_rst_o` pulse and command 0x0E gives a one-cycle `all_rst_o` pulse.
- R11: An end-of-packet token after one to three header bytes gives error code 4 and does not update the captured bytes. An end-of-packet token with no header bytes gives no error.
- R12: When `ack_en_i` is 1 and a header passes every check, `ack_push_o` pulses once. `ack_hdr_o` then carries the header with byte 0 in bits 7:0. A rejected header never pushes.
- R13: `mode_i` encodes 0 transparent, 1 routing, 2 protocol, 3 reserved. In any mode other than 2 the block ignores tokens: no pulse, no forwarding and no state change. On returning to mode 2 the next data token is header byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Channel mode; 2 enables interpretation |
| chan_addr_i | input | 8 | This channel's address |
| ack_en_i | input | 1 | Pass accepted headers to the acknowledge path |
| tok_valid_i | input | 1 | A received token is present |
| tok_eop_i | input | 1 | The token is an end-of-packet marker |
| tok_data_i | input | 8 | Data byte of the token |
| fwd_valid_o | output | 1 | Forwarded payload byte or end marker |
| fwd_data_o | output | 8 | Forwarded byte |
| fwd_eop_o | output | 1 | Forwarded item is the packet end |
| err_valid_o | output | 1 | Header error pulse |
| err_code_o | output | 3 | Error code (1 address, 2 command, 3 locked, 4 short) |
| hdr_tid_o | output | 8 | Last captured transaction-ID byte |
| hdr_ctrl_o | output | 8 | Last captured control byte |
| ack_push_o | output | 1 | Header handed to acknowledge path |
| ack_hdr_o | output | 32 | Header handed to acknowledge path |
| cpu_rst_o | output | 1 | CPU reset level |
| ext_sig_o | output | 4 | External signal levels |
| link_rst_o | output | 1 | Single link reset pulse |
| all_rst_o | output | 1 | All-links reset pulse |
| safety_armed_o | output | 1 | Safety-critical commands armed |

## Verification
A wrong header byte count shows up within one packet: a misplaced header shifts every later decision, so payload bytes get decoded as commands, or headers leak into the forwarded stream. A stuck or early-cleared arming flag appears on the next safety-critical command, either as a spurious code-3 error or as a reset pulse that should not occur. Because every effect is registered, each token's consequence is visible on the edge right after it is sampled. The bench compares every output after every token, so a fault is reported within one token of the packet that exposes it.

// File: rtl/phi_pkg.sv
`timescale 1ns/1ps
package phi_pkg;
  typedef enum logic [1:0] {
    MODE_TRANSP = 2'd0,
    MODE_ROUTE  = 2'd1,
    MODE_PROTO  = 2'd2,
    MODE_RSVD   = 2'd3
  } chan_mode_e;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_ADDR   = 3'd1,
    ERR_CMD    = 3'd2,
    ERR_LOCKED = 3'd3,
    ERR_SHORT  = 3'd4
  } hdr_err_e;

  typedef enum logic [2:0] {
    OP_BAD  = 3'd0,
    OP_DATA = 3'd1,
    OP_ARM  = 3'd2,
    OP_CPU  = 3'd3,
    OP_EXT  = 3'd4,
    OP_LINK = 3'd5,
    OP_ALL  = 3'd6
  } cmd_op_e;

  typedef struct packed {
    cmd_op_e    op;
    logic       level;
    logic       safety;
    logic [7:0] idx;
  } cmd_dec_t;
endpackage

// File: rtl/phi_hdr_collect.sv
`timescale 1ns/1ps
module phi_hdr_collect #(
  parameter int DW = 8,
  parameter int NB = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           active,
  input  logic           tok_valid,
  input  logic           tok_eop,
  input  logic [DW-1:0]  tok_data,
  output logic           hdr_done,
  output logic           short_eop,
  output logic           payload_tok,
  output logic [NB*DW-1:0] hdr_word
);
  localparam int CW = $clog2(NB + 1);
  localparam logic [CW-1:0] LAST = CW'(NB - 1);
  localparam logic [CW-1:0] FULL = CW'(NB);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] byte_q [NB-1];
  logic          data_tok;

  assign data_tok    = active & tok_valid & ~tok_eop;
  assign hdr_done    = data_tok && (cnt_q == LAST);
  assign short_eop   = active & tok_valid & tok_eop & (cnt_q != '0) & (cnt_q != FULL);
  assign payload_tok = active & tok_valid & (cnt_q == FULL);

  always_ff @(posedge clk) begin
    if (rst || !active)
      cnt_q <= '0;
    else if (tok_valid && tok_eop)
      cnt_q <= '0;
    else if (data_tok && cnt_q != FULL)
      cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (data_tok) begin
      for (int i = 0; i < NB - 1; i++)
        if (cnt_q == CW'(i)) byte_q[i] <= tok_data;
    end
  end

  for (genvar g = 0; g < NB - 1; g++) begin : g_word
    assign hdr_word[g*DW +: DW] = byte_q[g];
  end
  assign hdr_word[(NB-1)*DW +: DW] = tok_data;

  a_r11_short_not_done: assert property (@(posedge clk) disable iff (rst)
    short_eop |-> !hdr_done && !payload_tok);
endmodule

// File: rtl/phi_cmd_decode.sv
`timescale 1ns/1ps
module phi_cmd_decode #(
  parameter int DW    = 8,
  parameter int N_EXT = 4
) (
  input  logic [DW-1:0]     code,
  output phi_pkg::cmd_dec_t dec
);
  import phi_pkg::*;
  localparam int C_DATA    = 1;
  localparam int C_ARM     = 2;
  localparam int C_CPU_ON  = 3;
  localparam int C_CPU_OFF = 4;
  localparam int C_SET0    = 5;
  localparam int C_CLR0    = C_SET0 + N_EXT;
  localparam int C_LINK    = C_CLR0 + N_EXT;
  localparam int C_ALL     = C_LINK + 1;

  always_comb begin
    dec.op     = OP_BAD;
    dec.level  = 1'b0;
    dec.safety = 1'b0;
    dec.idx    = '0;
    if (code == DW'(C_DATA)) begin
      dec.op = OP_DATA;
    end else if (code == DW'(C_ARM)) begin
      dec.op = OP_ARM;
    end else if (code == DW'(C_CPU_ON) || code == DW'(C_CPU_OFF)) begin
      dec.op     = OP_CPU;
      dec.level  = (code == DW'(C_CPU_ON));
      dec.safety = 1'b1;
    end else if (code == DW'(C_LINK)) begin
      dec.op     = OP_LINK;
      dec.safety = 1'b1;
    end else if (code == DW'(C_ALL)) begin
      dec.op     = OP_ALL;
      dec.safety = 1'b1;
    end
    for (int i = 0; i < N_EXT; i++) begin
      if (code == DW'(C_SET0 + i)) begin
        dec.op = OP_EXT; dec.level = 1'b1; dec.idx = 8'(i);
      end
      if (code == DW'(C_CLR0 + i)) begin
        dec.op = OP_EXT; dec.level = 1'b0; dec.idx = 8'(i);
      end
    end
  end
endmodule

// File: rtl/phi_cmd_exec.sv
`timescale 1ns/1ps
module phi_cmd_exec #(
  parameter int N_EXT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  phi_pkg::cmd_dec_t dec,
  output logic              armed_o,
  output logic              cpu_rst_o,
  output logic              link_rst_o,
  output logic              all_rst_o,
  output logic [N_EXT-1:0]  ext_o
);
  import phi_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_o    <= 1'b0;
      cpu_rst_o  <= 1'b0;
      link_rst_o <= 1'b0;
      all_rst_o  <= 1'b0;
    end else begin
      link_rst_o <= 1'b0;
      all_rst_o  <= 1'b0;
      if (go) begin
        case (dec.op)
          OP_ARM:  armed_o <= 1'b1;
          OP_CPU:  begin cpu_rst_o  <= dec.level; armed_o <= 1'b0; end
          OP_LINK: begin link_rst_o <= 1'b1;      armed_o <= 1'b0; end
          OP_ALL:  begin all_rst_o  <= 1'b1;      armed_o <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    always_ff @(posedge clk) begin
      if (rst)
        ext_o[g] <= 1'b0;
      else if (go && dec.op == OP_EXT && dec.idx == 8'(g))
        ext_o[g] <= dec.level;
    end
  end

  a_r6_cpu_change_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $changed(cpu_rst_o) |-> $past(armed_o));
  a_r6_disarm_after_safety: assert property (@(posedge clk) disable iff (rst)
    (link_rst_o || all_rst_o) |-> !armed_o);
endmodule

// File: rtl/pkt_hdr_interp.sv
`timescale 1ns/1ps
module pkt_hdr_interp #(
  parameter int DW    = 8,
  parameter int NB    = 4,
  parameter int N_EXT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic [DW-1:0]    chan_addr_i,
  input  logic             ack_en_i,
  input  logic             tok_valid_i,
  input  logic             tok_eop_i,
  input  logic [DW-1:0]    tok_data_i,
  output logic             fwd_valid_o,
  output logic [DW-1:0]    fwd_data_o,
  output logic             fwd_eop_o,
  output logic             err_valid_o,
  output logic [2:0]       err_code_o,
  output logic [DW-1:0]    hdr_tid_o,
  output logic [DW-1:0]    hdr_ctrl_o,
  output logic             ack_push_o,
  output logic [NB*DW-1:0] ack_hdr_o,
  output logic             cpu_rst_o,
  output logic [N_EXT-1:0] ext_sig_o,
  output logic             link_rst_o,
  output logic             all_rst_o,
  output logic             safety_armed_o
);
  import phi_pkg::*;
  localparam int P_DEST = 0;
  localparam int P_CMD  = 1;
  localparam int P_TID  = 2;
  localparam int P_CTRL = 3;

  logic             active;
  logic             hdr_done, short_eop, payload_tok;
  logic [NB*DW-1:0] hdr_word;
  cmd_dec_t         dec;
  hdr_err_e         err_d;
  logic             clean;
  logic             fwd_en_q;

  assign active = (mode_i == MODE_PROTO);

  phi_hdr_collect #(.DW(DW), .NB(NB)) u_collect (
    .clk(clk), .rst(rst), .active(active),
    .tok_valid(tok_valid_i), .tok_eop(tok_eop_i), .tok_data(tok_data_i),
    .hdr_done(hdr_done), .short_eop(short_eop), .payload_tok(payload_tok),
    .hdr_word(hdr_word)
  );

  phi_cmd_decode #(.DW(DW), .N_EXT(N_EXT)) u_decode (
    .code(hdr_word[P_CMD*DW +: DW]), .dec(dec)
  );

  always_comb begin
    err_d = ERR_NONE;
    if (short_eop)
      err_d = ERR_SHORT;
    else if (hdr_done) begin
      if (hdr_word[P_DEST*DW +: DW] != chan_addr_i) err_d = ERR_ADDR;
      else if (dec.op == OP_BAD)                    err_d = ERR_CMD;
      else if (dec.safety && !safety_armed_o)       err_d = ERR_LOCKED;
    end
  end
  assign clean = hdr_done && (err_d == ERR_NONE);

  phi_cmd_exec #(.N_EXT(N_EXT)) u_exec (
    .clk(clk), .rst(rst), .go(clean), .dec(dec),
    .armed_o(safety_armed_o), .cpu_rst_o(cpu_rst_o),
    .link_rst_o(link_rst_o), .all_rst_o(all_rst_o), .ext_o(ext_sig_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_en_q    <= 1'b0;
      fwd_valid_o <= 1'b0;
      fwd_data_o  <= '0;
      fwd_eop_o   <= 1'b0;
      err_valid_o <= 1'b0;
      err_code_o  <= ERR_NONE;
      ack_push_o  <= 1'b0;
      ack_hdr_o   <= '0;
      hdr_tid_o   <= '0;
      hdr_ctrl_o  <= '0;
    end else begin
      fwd_valid_o <= payload_tok & fwd_en_q;
      fwd_data_o  <= tok_data_i;
      fwd_eop_o   <= tok_eop_i;
      err_valid_o <= (err_d != ERR_NONE);
      err_code_o  <= err_d;
      ack_push_o  <= clean & ack_en_i;
      if (hdr_done) begin
        hdr_tid_o  <= hdr_word[P_TID*DW +: DW];
        hdr_ctrl_o <= hdr_word[P_CTRL*DW +: DW];
        ack_hdr_o  <= hdr_word;
      end
      if (!active)
        fwd_en_q <= 1'b0;
      else if (hdr_done)
        fwd_en_q <= clean && (dec.op == OP_DATA);
      else if (tok_valid_i && tok_eop_i)
        fwd_en_q <= 1'b0;
    end
  end

  a_r4_err_blocks_fwd: assert property (@(posedge clk) disable iff (rst)
    err_valid_o |-> !fwd_valid_o);
  a_r10_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({link_rst_o, all_rst_o, err_valid_o, fwd_valid_o}));
  a_r12_ack_never_on_err: assert property (@(posedge clk) disable iff (rst)
    ack_push_o |-> !err_valid_o);
  a_r7_locked_keeps_cpu: assert property (@(posedge clk) disable iff (rst)
    (err_valid_o && err_code_o == 3'd3) |-> $stable(cpu_rst_o));
  a_r13_bypass_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i) != 2'd2) |-> !(fwd_valid_o || err_valid_o || ack_push_o || link_rst_o || all_rst_o));
endmodule

// File: tb/pkt_hdr_interp_tb.sv
`timescale 1ns/1ps
module pkt_hdr_interp_tb;
  localparam logic [7:0] CH = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'd2;
  logic        ack_en = 1'b0;
  logic        tok_valid = 1'b0, tok_eop = 1'b0;
  logic [7:0]  tok_data = 8'h00;
  logic        fwd_valid, fwd_eop, err_valid, ack_push, cpu_rst, link_rst, all_rst, armed;
  logic [7:0]  fwd_data, hdr_tid, hdr_ctrl;
  logic [2:0]  err_code;
  logic [31:0] ack_hdr;
  logic [3:0]  ext_sig;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // model state
  int         m_cnt = 0;
  bit         m_fwd = 0, m_armed = 0, m_cpu = 0;
  logic [3:0] m_ext = 0;
  logic [7:0] m_hdr [4];
  logic [7:0] m_tid = 0, m_ctrl = 0;
  // expected per-token outputs
  bit         e_fwd_v, e_fwd_eop, e_err_v, e_link, e_all, e_ack;
  logic [7:0] e_fwd_d;
  logic [2:0] e_err_c;
  logic [31:0] e_ack_hdr;

  always #5 clk = ~clk;

  pkt_hdr_interp u_dut (
    .clk(clk), .rst(rst), .mode_i(mode), .chan_addr_i(CH), .ack_en_i(ack_en),
    .tok_valid_i(tok_valid), .tok_eop_i(tok_eop), .tok_data_i(tok_data),
    .fwd_valid_o(fwd_valid), .fwd_data_o(fwd_data), .fwd_eop_o(fwd_eop),
    .err_valid_o(err_valid), .err_code_o(err_code),
    .hdr_tid_o(hdr_tid), .hdr_ctrl_o(hdr_ctrl),
    .ack_push_o(ack_push), .ack_hdr_o(ack_hdr),
    .cpu_rst_o(cpu_rst), .ext_sig_o(ext_sig),
    .link_rst_o(link_rst), .all_rst_o(all_rst), .safety_armed_o(armed)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_safety(logic [7:0] c);
    return c == 8'h03 || c == 8'h04 || c == 8'h0D || c == 8'h0E;
  endfunction

  function automatic string err_tag(logic [2:0] c);
    case (c)
      3'd1: return "R4 address error";
      3'd2: return "R5 invalid command";
      3'd3: return "R7 locked safety command";
      3'd4: return "R11 short header";
      default: return "R4 no error expected";
    endcase
  endfunction

  task automatic decide();
    logic [7:0] c;
    logic [2:0] er;
    c = m_hdr[1];
    m_tid = m_hdr[2];
    m_ctrl = m_hdr[3];
    e_ack_hdr = {m_hdr[3], m_hdr[2], m_hdr[1], m_hdr[0]};
    er = 0;
    if (m_hdr[0] != CH) er = 1;
    else if (c == 8'h00 || c > 8'h0E) er = 2;
    else if (is_safety(c) && !m_armed) er = 3;
    m_fwd = 0;
    if (er != 0) begin
      e_err_v = 1; e_err_c = er;
    end else begin
      e_ack = ack_en;
      case (c)
        8'h01: m_fwd = 1;
        8'h02: m_armed = 1;
        8'h03: begin m_cpu = 1; m_armed = 0; end
        8'h04: begin m_cpu = 0; m_armed = 0; end
        8'h0D: begin e_link = 1; m_armed = 0; end
        8'h0E: begin e_all = 1; m_armed = 0; end
        default: begin
          if (c >= 8'h05 && c <= 8'h08) m_ext[c - 8'h05] = 1'b1;
          else m_ext[c - 8'h09] = 1'b0;
        end
      endcase
    end
  endtask

  task automatic model_tok(bit eop, logic [7:0] d);
    e_fwd_v = 0; e_fwd_eop = 0; e_fwd_d = 0; e_err_v = 0; e_err_c = 0;
    e_link = 0; e_all = 0; e_ack = 0;
    if (mode != 2'd2) return;
    if (eop) begin
      if (m_cnt > 0 && m_cnt < 4) begin e_err_v = 1; e_err_c = 4; end
      else if (m_cnt == 4 && m_fwd) begin e_fwd_v = 1; e_fwd_eop = 1; end
      m_cnt = 0; m_fwd = 0;
    end else if (m_cnt < 4) begin
      m_hdr[m_cnt] = d;
      m_cnt++;
      if (m_cnt == 4) decide();
    end else if (m_fwd) begin
      e_fwd_v = 1; e_fwd_d = d;
    end
  endtask

  task automatic compare_all();
    bit byp;
    byp = (mode != 2'd2);
    check(byp ? "R13 fwd_valid" : "R3 fwd_valid", 32'(fwd_valid), 32'(e_fwd_v));
    if (e_fwd_v) begin
      check("R3 fwd_eop", 32'(fwd_eop), 32'(e_fwd_eop));
      if (!e_fwd_eop) check("R3 fwd_data", 32'(fwd_data), 32'(e_fwd_d));
    end
    check(byp ? "R13 err_valid" : err_tag(e_err_c), 32'(err_valid), 32'(e_err_v));
    if (e_err_v) check(err_tag(e_err_c), 32'(err_code), 32'(e_err_c));
    check(byp ? "R13 ack_push" : "R12 ack_push", 32'(ack_push), 32'(e_ack));
    if (e_ack) check("R12 ack_hdr", ack_hdr, e_ack_hdr);
    check("R8 cpu_rst", 32'(cpu_rst), 32'(m_cpu));
    check("R9 ext_sig", 32'(ext_sig), 32'(m_ext));
    check("R10 link_rst", 32'(link_rst), 32'(e_link));
    check("R10 all_rst", 32'(all_rst), 32'(e_all));
    check("R6 armed", 32'(armed), 32'(m_armed));
    check("R2 hdr_tid", 32'(hdr_tid), 32'(m_tid));
    check("R2 hdr_ctrl", 32'(hdr_ctrl), 32'(m_ctrl));
  endtask

  task automatic send(bit eop, logic [7:0] d);
    @(negedge clk);
    tok_valid = 1; tok_eop = eop; tok_data = d;
    model_tok(eop, d);
    @(negedge clk);
    tok_valid = 0; tok_eop = 0;
    compare_all();
  endtask

  task automatic send_pkt(logic [7:0] dst, logic [7:0] cmd, logic [7:0] tid,
                          logic [7:0] ctl, int npay);
    send(0, dst); send(0, cmd); send(0, tid); send(0, ctl);
    for (int i = 0; i < npay; i++) send(0, 8'($urandom));
    send(1, 8'h00);
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk);
    mode = m;
    if (m != 2'd2) begin m_cnt = 0; m_fwd = 0; end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1355_00A7));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 fwd_valid", 32'(fwd_valid), 0);
    check("R1 err_valid", 32'(err_valid), 0);
    check("R1 cpu_rst", 32'(cpu_rst), 0);
    check("R1 ext_sig", 32'(ext_sig), 0);
    check("R1 armed", 32'(armed), 0);
    check("R1 tid", 32'(hdr_tid), 0);
    check("R1 ctrl", 32'(hdr_ctrl), 0);
    check("R1 pulses", 32'({link_rst, all_rst, ack_push}), 0);

    // R3 data write with payload, R2 capture
    send_pkt(CH, 8'h01, 8'hA1, 8'hC1, 3);
    // R9 external signals
    send_pkt(CH, 8'h05, 8'h01, 8'h02, 0);
    send_pkt(CH, 8'h08, 8'h03, 8'h04, 1);
    send_pkt(CH, 8'h09, 8'h05, 8'h06, 0);
    // R7 locked, R6/R8 armed path
    send_pkt(CH, 8'h03, 8'h10, 8'h11, 0);
    send_pkt(CH, 8'h02, 8'h12, 8'h13, 0);
    send_pkt(CH, 8'h06, 8'h14, 8'h15, 0);   // R9 ext keeps arming
    send_pkt(CH, 8'h03, 8'h16, 8'h17, 0);
    send_pkt(CH, 8'h04, 8'h18, 8'h19, 0);   // locked again
    send_pkt(CH, 8'h02, 8'h1A, 8'h1B, 0);
    send_pkt(CH, 8'h04, 8'h1C, 8'h1D, 0);
    // R10 resets
    send_pkt(CH, 8'h02, 8'h20, 8'h21, 0);
    send_pkt(CH, 8'h0D, 8'h22, 8'h23, 0);
    send_pkt(CH, 8'h02, 8'h24, 8'h25, 0);
    send_pkt(CH, 8'h0E, 8'h26, 8'h27, 2);
    // R4 mismatch with data command, R4 priority over bad code
    send_pkt(CH ^ 8'h01, 8'h01, 8'h30, 8'h31, 3);
    send_pkt(8'h00, 8'hFF, 8'h32, 8'h33, 1);
    // R5 invalid codes
    send_pkt(CH, 8'h00, 8'h34, 8'h35, 2);
    send_pkt(CH, 8'h0F, 8'h36, 8'h37, 1);
    send_pkt(CH, 8'hFF, 8'h38, 8'h39, 0);
    // R11 short headers and empty packet
    send(0, CH); send(0, 8'h01); send(1, 8'h00);
    send(0, CH); send(1, 8'h00);
    send(0, CH); send(0, 8'h01); send(0, 8'h77); send(1, 8'h00);
    send(1, 8'h00);
    send_pkt(CH, 8'h01, 8'h40, 8'h41, 1);
    // R12 acknowledge path
    ack_en = 1;
    send_pkt(CH, 8'h01, 8'h50, 8'h51, 2);
    send_pkt(CH, 8'h07, 8'h52, 8'h53, 0);
    send_pkt(CH, 8'h03, 8'h54, 8'h55, 0);   // locked: no push
    ack_en = 0;
    // R13 bypass, including a half-received header
    send(0, CH); send(0, 8'h01);
    set_mode(2'd0);
    send_pkt(CH, 8'h02, 8'h60, 8'h61, 1);
    set_mode(2'd1);
    send_pkt(CH, 8'h05, 8'h62, 8'h63, 0);
    set_mode(2'd3);
    send(0, CH);
    set_mode(2'd2);
    send_pkt(CH, 8'h01, 8'h64, 8'h65, 2);

    // constrained random
    for (int p = 0; p < 400; p++) begin
      logic [7:0] dst, cmd;
      int r;
      r = int'($urandom % 100);
      if (r < 4) begin
        set_mode(2'($urandom % 2 == 0 ? 0 : 1 + $urandom % 3 * 0 + ($urandom % 2) * 2));
        for (int k = 0; k < 3; k++) send(bit'($urandom % 4 == 0), 8'($urandom));
        set_mode(2'd2);
      end
      ack_en = bit'($urandom % 2);
      dst = ($urandom % 4 != 0) ? CH : 8'($urandom);
      r = int'($urandom % 10);
      if (r < 3) cmd = 8'h02;
      else if (r == 3) cmd = 8'($urandom);
      else cmd = 8'($urandom % 16);
      if ($urandom % 10 == 0) begin
        int k;
        k = 1 + int'($urandom % 3);
        for (int i = 0; i < k; i++) send(0, i == 0 ? dst : 8'($urandom));
        send(1, 8'h00);
      end else begin
        send_pkt(dst, cmd, 8'($urandom), 8'($urandom), int'($urandom % 4));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule